// File: doc/BRIEF.md
# Page Program Data Buffer

This block collects the data bytes of a page program command into a local page-sized buffer, then replays them to a flash array write port. A command front end calls `start_i` with the 19-bit starting address once the command and its address have been decoded. It then presents one data byte per `byte_vld_i` strobe. When chip select rises, the front end reports two things. `cs_aligned_i` says whether the rise fell on a byte boundary. `accept_i` says whether the permission and busy logic elsewhere allows the write.

Bytes land at a running offset that wraps inside the selected page, so a long burst keeps only the most recent page's worth of data. A per-location loaded mask decides which offsets are replayed. A qualifying commit scans every offset in ascending order. For each loaded location it issues one write of the buffered byte to the array, and it ends with a single-cycle done pulse. The array merges each written byte into the stored value as an AND of the old and new data. That merge belongs to the array, outside this block.

Top module: `page_prog_buf`

## Requirements
- R1: While `rst_ni` is low, and after reset until a commit, `wr_vld_o`, `done_o` and `busy_o` are 0.
- R2: When `busy_o` is low, `start_i` does three things. It takes the page number from `addr_i[18:8]` and the starting offset from `addr_i[7:0]`. It clears the loaded mask. It arms the buffer, so bytes of an earlier command are never written.
- R3: Each `byte_vld_i` strobe on an armed, idle buffer stores `byte_i` at the current offset and marks that offset loaded. The offset then advances by one and wraps from 0xFF to 0x00 inside the same page.
- R4: A byte stored at an offset already loaded replaces the earlier byte. When more than 256 bytes are sent, only the last 256 are written.
- R5: A commit starts only when four things hold on `cs_rise_i`: `cs_aligned_i` is 1, `accept_i` is 1, the buffer is armed, and at least one byte has been loaded. Any other `cs_rise_i` on an idle block disarms the buffer with no writes and no done pulse. A later rise without a new `start_i` also produces nothing.
- R6: During a commit, `wr_vld_o` pulses once for each loaded offset and for no other offset, in strictly ascending offset order. Each pulse carries `wr_addr_o = {page, offset}` and `wr_data_o` set to the byte kept for that offset.
- R7: `done_o` is high for exactly one cycle, after the last write of a commit. `busy_o` is low in that cycle.
- R8: While `busy_o` is high, `byte_vld_i`, `start_i` and `cs_rise_i` are ignored.
- R9: A chip-select rise with no bytes loaded since `start_i` causes no writes and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | New page program command, address valid |
| addr_i | input | 19 | Starting byte address (page in [18:8], offset in [7:0]) |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | Chip select has risen |
| cs_aligned_i | input | 1 | The rise fell on a byte boundary |
| accept_i | input | 1 | Write permitted by the protection and busy logic |
| wr_vld_o | output | 1 | Array write strobe |
| wr_addr_o | output | 19 | Array write address |
| wr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Commit in progress |
| done_o | output | 1 | Commit finished, one-cycle pulse |

## Verification
The assertions assume that `start_i`, `byte_vld_i` and `cs_rise_i` are never high in the same cycle. They also assume that chip-select rises are reported only while the block is idle or for an ignored rise. The bench drives each event as its own one-cycle strobe, separated by idle cycles, so these conditions always hold. Random bursts from 1 to 300 bytes at random addresses cover both wrap-around and overwrite. Strobes injected during a commit check that the block stays inert while busy.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } pp_state_e;
endpackage

// File: rtl/pp_page_store.sv
module pp_page_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_hit_o,
  output logic              any_o
);
  logic [DEPTH-1:0]  mask_q;
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mask_q[g] <= 1'b0;
      else if (clr_i)                               mask_q[g] <= 1'b0;
      else if (wr_i && wr_off_i == OFF_W'(g))       mask_q[g] <= 1'b1;
    end
    always_ff @(posedge clk_i) begin
      if (wr_i && wr_off_i == OFF_W'(g)) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_off_i];
  assign rd_hit_o  = mask_q[rd_off_i];
  assign any_o     = |mask_q;
endmodule

// File: rtl/pp_commit_seq.sv
module pp_commit_seq
  import pp_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  output logic [OFF_W-1:0] scan_off_o,
  output logic             scan_en_o,
  output logic             busy_o,
  output logic             done_o
);
  pp_state_e        state_q;
  logic [OFF_W-1:0] idx_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          state_q <= ST_SCAN;
          idx_q   <= '0;
        end
        ST_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == '1) state_q <= ST_FIN;
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_off_o = idx_q;
  assign scan_en_o  = (state_q == ST_SCAN);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/page_prog_buf.sv
module page_prog_buf #(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              cs_rise_i,
  input  logic              cs_aligned_i,
  input  logic              accept_i,
  output logic              wr_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              armed_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  ptr_q;
  logic              start_ok, byte_ok, commit, drop;
  logic              any_loaded, rd_hit, scan_en;
  logic [OFF_W-1:0]  scan_off;
  logic [DATA_W-1:0] rd_data;
  logic              wr_vld_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  assign start_ok = start_i & ~busy_o;
  assign byte_ok  = byte_vld_i & armed_q & ~busy_o & ~start_i;
  assign commit   = cs_rise_i & ~busy_o & armed_q & cs_aligned_i & accept_i & any_loaded;
  assign drop     = cs_rise_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      page_q  <= '0;
      ptr_q   <= '0;
    end else if (start_ok) begin
      armed_q <= 1'b1;
      page_q  <= addr_i[ADDR_W-1:OFF_W];
      ptr_q   <= addr_i[OFF_W-1:0];
    end else if (drop) begin
      armed_q <= 1'b0;
    end else if (byte_ok) begin
      ptr_q   <= ptr_q + 1'b1;  // wraps inside the page
    end
  end

  pp_page_store #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_ok),
    .wr_i      (byte_ok),
    .wr_off_i  (ptr_q),
    .wr_data_i (byte_i),
    .rd_off_i  (scan_off),
    .rd_data_o (rd_data),
    .rd_hit_o  (rd_hit),
    .any_o     (any_loaded)
  );

  pp_commit_seq #(.OFF_W(OFF_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (commit),
    .scan_off_o (scan_off),
    .scan_en_o  (scan_en),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_vld_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_vld_q <= scan_en & rd_hit;
      if (scan_en) begin
        wr_addr_q <= {page_q, scan_off};
        wr_data_q <= rd_data;
      end
    end
  end

  assign wr_vld_o  = wr_vld_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  // R6
  wr_in_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> wr_addr_o[ADDR_W-1:OFF_W] == page_q);
  // R6
  wr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o && $past(wr_vld_o) |-> wr_addr_o[OFF_W-1:0] > $past(wr_addr_o[OFF_W-1:0]));
  // R6
  no_wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> busy_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R5
  discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i && !cs_aligned_i && !busy_o |=> !busy_o);
  // R9
  nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> any_loaded);
endmodule

// File: tb/tb_page_prog_buf.sv
module tb_page_prog_buf;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [18:0] addr_i = '0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        cs_rise_i = 1'b0, cs_aligned_i = 1'b0, accept_i = 1'b0;
  logic        wr_vld_o, busy_o, done_o;
  logic [18:0] wr_addr_o;
  logic [7:0]  wr_data_o;

  always #5 clk = ~clk;

  page_prog_buf dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .cs_rise_i(cs_rise_i),
    .cs_aligned_i(cs_aligned_i), .accept_i(accept_i), .wr_vld_o(wr_vld_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [7:0]   exp_buf [256];
  logic [255:0] exp_mask;
  logic [10:0]  exp_page;
  logic [7:0]   exp_ptr;
  bit           exp_armed;
  int           got_cnt, done_seen;
  logic [18:0]  got_addr [512];
  logic [7:0]   got_data [512];

  always @(negedge clk) begin
    if (wr_vld_o && got_cnt < 512) begin
      got_addr[got_cnt] = wr_addr_o;
      got_data[got_cnt] = wr_data_o;
      got_cnt++;
    end
    if (done_o) done_seen++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      report();
    end
  end

  task automatic do_start(input logic [18:0] a, input bit model);
    @(negedge clk); start_i = 1; addr_i = a;
    @(negedge clk); start_i = 0;
    if (model) begin
      exp_mask = '0; exp_page = a[18:8]; exp_ptr = a[7:0]; exp_armed = 1;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit model);
    @(negedge clk); byte_vld_i = 1; byte_i = b;
    @(negedge clk); byte_vld_i = 0;
    if (model && exp_armed) begin
      exp_buf[exp_ptr] = b; exp_mask[exp_ptr] = 1'b1; exp_ptr = exp_ptr + 8'd1;
    end
  endtask

  task automatic rise(input bit aligned, input bit acc);
    @(posedge clk); got_cnt = 0; done_seen = 0;
    @(negedge clk); cs_rise_i = 1; cs_aligned_i = aligned; accept_i = acc;
    @(negedge clk); cs_rise_i = 0; cs_aligned_i = 0; accept_i = 0;
  endtask

  task automatic collect(input bit expect_commit, input string req);
    int k;
    for (int w = 0; w < 400 && done_seen == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    if (!expect_commit) begin
      check(got_cnt == 0, req, got_cnt, 0);
      check(done_seen == 0, req, done_seen, 0);
    end else begin
      check(done_seen == 1, "R7", done_seen, 1);
      check(busy_o == 0, "R7", busy_o, 0);
      check(got_cnt == $countones(exp_mask), "R6", got_cnt, $countones(exp_mask));
      k = 0;
      for (int o = 0; o < 256; o++) begin
        if (exp_mask[o] && k < got_cnt) begin
          check(got_addr[k] == {exp_page, 8'(o)}, req, got_addr[k], {exp_page, 8'(o)});
          check(got_data[k] == exp_buf[o], req, got_data[k], exp_buf[o]);
          k++;
        end
      end
    end
    exp_armed = 0;
  endtask

  task automatic commit_expect(input bit aligned, input bit acc, input string req);
    bit ok;
    ok = exp_armed && aligned && acc && (exp_mask != '0);
    rise(aligned, acc);
    collect(ok, req);
  endtask

  initial begin
    int unsigned seed;
    int n;
    seed = $urandom(32'd20240611);
    exp_mask = '0; exp_armed = 0; exp_page = '0; exp_ptr = '0;
    got_cnt = 0; done_seen = 0;
    repeat (3) @(negedge clk);
    // R1
    check(wr_vld_o == 0 && done_o == 0 && busy_o == 0, "R1", {wr_vld_o, done_o, busy_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    check(wr_vld_o == 0 && done_o == 0 && busy_o == 0, "R1", {wr_vld_o, done_o, busy_o}, 0);

    // R3 R6 single byte
    do_start(19'h12345, 1); send_byte(8'hA5, 1); commit_expect(1, 1, "R6");
    // R3 wrap from high offset
    do_start(19'h3A0F0, 1);
    for (int i = 0; i < 40; i++) send_byte(8'(i * 7 + 3), 1);
    commit_expect(1, 1, "R3");
    // R4 more than a page
    do_start(19'h01080, 1);
    for (int i = 0; i < 300; i++) send_byte(8'($urandom), 1);
    check($countones(exp_mask) == 256, "R4", $countones(exp_mask), 256);
    commit_expect(1, 1, "R4");
    // R2 second start clears earlier bytes
    do_start(19'h22210, 1);
    for (int i = 0; i < 10; i++) send_byte(8'hC0 + 8'(i), 1);
    do_start(19'h45678, 1);
    for (int i = 0; i < 3; i++) send_byte(8'h11 * 8'(i + 1), 1);
    commit_expect(1, 1, "R2");
    // R5 unaligned rise, then a later aligned rise without start
    do_start(19'h00100, 1); send_byte(8'h5A, 1);
    commit_expect(0, 1, "R5");
    send_byte(8'h77, 1);
    commit_expect(1, 1, "R5");
    // R5 not accepted
    do_start(19'h00200, 1); send_byte(8'h3C, 1);
    commit_expect(1, 0, "R5");
    // R9 no data bytes
    do_start(19'h00300, 1);
    commit_expect(1, 1, "R9");
    // R8 strobes during commit are ignored
    do_start(19'h7FF00, 1);
    for (int i = 0; i < 5; i++) send_byte(8'hF0 | 8'(i), 1);
    rise(1, 1);
    check(busy_o == 1, "R8", busy_o, 1);
    do_start(19'h11111, 0);
    send_byte(8'hEE, 0);
    send_byte(8'hDD, 0);
    @(negedge clk); cs_rise_i = 1; cs_aligned_i = 1; accept_i = 1;
    @(negedge clk); cs_rise_i = 0; cs_aligned_i = 0; accept_i = 0;
    collect(1, "R8");
    rise(1, 1);
    collect(0, "R8");
    // random bursts
    for (int t = 0; t < 8; t++) begin
      do_start(19'($urandom), 1);
      n = 1 + int'($urandom % 300);
      for (int i = 0; i < n; i++) send_byte(8'($urandom), 1);
      commit_expect(1, 1, "R6");
    end
    finished = 1;
    report();
  end
endmodule